// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for the two-wire PHY management bus. Software fills a 16-bit transmit data register, picks the frame clause and whether a preamble is sent, then writes a command word that holds an opcode, a port (PHY) address and a register or device address. Writing the command starts one management frame, which the block shifts out on MDIO, timed by an MDC clock divided down from the system clock.

The same two-bit opcode means different things in the two clauses. Under Clause 22, opcode 1 reads and opcode 0 writes. Under Clause 45, opcode 0 is an address cycle, opcode 1 writes and opcode 3 reads. For reads, the block releases MDIO through the turnaround and the data field, and it samples the sixteen bits the PHY returns. Progress shows in the two data registers: bit 17 is a busy flag and bit 16 says the last transfer has finished. A Clause 45 register read takes two frames. An address cycle carries the register number in its data field, and a read cycle follows it.

Software reaches the block through a single-cycle 64-bit register port. A write strobe stores data in one cycle, and read data is a combinational function of the address. An enable register gates the whole interface.

Top module: `mdio_master`

## Requirements
- R1: After reset, every register reads as zero, MDC is low and MDIO is not driven (output enable low).
- R2: A command accepted at offset 0x00 sets bit 17 of the read-data register at 0x10 for a read, or bit 17 of the write-data register at 0x08 otherwise, from the next cycle until the frame ends. The command fields are register/device address at bits 4:0, port address at bits 12:8 and opcode at bits 17:16.
- R3: While bit 0 of the enable register at 0x20 is 0 and no frame runs, a command write starts nothing and leaves the command readback unchanged, MDC stays low and MDIO stays released.
- R4: A command written while a frame runs is ignored. The command readback is unchanged, and the running frame keeps the data it loaded even if 0x08 is rewritten.
- R5: With bit 24 of 0x18 at 0, the frame starts with bits 01. Opcode 1 is a read, sent as 10 on the wire. Opcode 0 is a write, sent as 01.
- R6: With bit 24 of 0x18 at 1, the frame starts with bits 00 and the opcode goes out unchanged. Opcode 0 is an address cycle, opcode 1 is a write and opcode 3 is a read.
- R7: With bit 12 of 0x18 at 1, 32 driven ones come before the frame. With it at 0, the frame has exactly 32 bit times.
- R8: After the start, opcode, port address (5 bits) and register/device address (5 bits), all sent MSB first, a write or address frame drives turnaround 10 and then bits 15:0 of 0x08, MSB first.
- R9: A read frame leaves MDIO released for the 2 turnaround and 16 data bit times. It samples MDIO on 16 MDC rising edges, MSB first. At the end it shows the value in bits 15:0 of 0x10 and sets bit 16 of 0x10.
- R10: Issuing a read clears bit 16 of 0x10 until that read completes.
- R11: MDC has a period of 2*HALF_DIV system clocks while running, and MDIO and its enable change only in the cycle where MDC falls.
- R12: Issuing a write or address frame clears bit 16 of 0x08, and completing it sets that bit again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
Two things can happen in the same cycle: a software register write and the shifter consuming the frame it loaded. The bench provokes this by issuing a write frame, then at once writing a different command and a new transmit word while the first frame is still shifting. It judges the result at the pins and through the register port. The captured bit stream must match the first command with its original data, the command readback must stay the first command, and the transmit register must read back the new word. The same applies to the read-valid flag: it is cleared when a read is accepted and set again on the edge where the frame retires, so the bench reads it immediately after issue and again after completion.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_AW     = 8;
  localparam int REG_DW     = 64;
  localparam int DATA_BITS  = 16;
  localparam int FIELD_W    = 5;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 32;

  localparam logic [REG_AW-1:0] OFS_CMD  = 8'h00;
  localparam logic [REG_AW-1:0] OFS_TXD  = 8'h08;
  localparam logic [REG_AW-1:0] OFS_RXD  = 8'h10;
  localparam logic [REG_AW-1:0] OFS_MODE = 8'h18;
  localparam logic [REG_AW-1:0] OFS_EN   = 8'h20;

  localparam int RA_LSB    = 0;
  localparam int PA_LSB    = 8;
  localparam int OP_LSB    = 16;
  localparam int VAL_BIT   = 16;
  localparam int BUSY_BIT  = 17;
  localparam int PRE_BIT   = 12;
  localparam int CL45_BIT  = 24;
  localparam int EN_BIT    = 0;

  typedef struct packed {
    logic [1:0]         op;
    logic [FIELD_W-1:0] port;
    logic [FIELD_W-1:0] addr;
  } mgmt_cmd_t;

  function automatic logic op_reads(input logic [1:0] op, input logic cl45);
    return cl45 ? op[1] : op[0];
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          wrap;

  always_comb begin
    wrap  = run && (cnt_q == LAST);
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc      = mdc_q;
  assign rise_stb = wrap && !mdc_q;
  assign fall_stb = wrap && mdc_q;

  // R11
  mdc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(mdc_q));
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  mgmt_cmd_t cmd,
  input  logic      cl45,
  input  logic      pre_en,
  input  logic [DATA_BITS-1:0] txd,
  input  logic      rise_stb,
  input  logic      fall_stb,
  input  logic      mdio_i,
  output logic      mdio_o,
  output logic      mdio_oe,
  output logic      busy,
  output logic      busy_rd,
  output logic      done,
  output logic [DATA_BITS-1:0] rxd
);
  localparam int SH_W  = PRE_BITS + FRAME_BITS;
  localparam int CNT_W = $clog2(SH_W + 1);
  localparam int HDR_W = FRAME_BITS - DATA_BITS - 2;

  logic                  is_rd;
  logic [1:0]            st_f, op_f, ta_f, ta_oe;
  logic [FRAME_BITS-1:0] frm, frm_oe, frm_smp;
  logic [SH_W-1:0]       ld_sh, ld_oe, ld_smp;
  logic [CNT_W-1:0]      ld_cnt;

  logic [SH_W-1:0]       sh_q, sh_d, oes_q, oes_d, smp_q, smp_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  busy_q, busy_d, rd_q, rd_d;
  logic                  o_q, o_d, oe_q, oe_d, cur_smp_q, cur_smp_d;
  logic [DATA_BITS-1:0]  rx_q, rx_d;

  // frame image assembled at acceptance time
  always_comb begin
    is_rd   = op_reads(cmd.op, cl45);
    st_f    = cl45 ? 2'b00 : 2'b01;
    op_f    = cl45 ? cmd.op : (is_rd ? 2'b10 : 2'b01);
    ta_f    = is_rd ? 2'b00 : 2'b10;
    ta_oe   = is_rd ? 2'b00 : 2'b11;
    frm     = {st_f, op_f, cmd.port, cmd.addr, ta_f,
               is_rd ? {DATA_BITS{1'b0}} : txd};
    frm_oe  = {{HDR_W{1'b1}}, ta_oe, {DATA_BITS{!is_rd}}};
    frm_smp = {{(FRAME_BITS-DATA_BITS){1'b0}}, {DATA_BITS{is_rd}}};
    if (pre_en) begin
      ld_sh  = {{PRE_BITS{1'b1}}, frm};
      ld_oe  = {{PRE_BITS{1'b1}}, frm_oe};
      ld_smp = {{PRE_BITS{1'b0}}, frm_smp};
      ld_cnt = CNT_W'(SH_W);
    end else begin
      ld_sh  = {frm, {PRE_BITS{1'b0}}};
      ld_oe  = {frm_oe, {PRE_BITS{1'b0}}};
      ld_smp = {frm_smp, {PRE_BITS{1'b0}}};
      ld_cnt = CNT_W'(FRAME_BITS);
    end
  end

  always_comb begin
    sh_d      = sh_q;
    oes_d     = oes_q;
    smp_d     = smp_q;
    cnt_d     = cnt_q;
    busy_d    = busy_q;
    rd_d      = rd_q;
    o_d       = o_q;
    oe_d      = oe_q;
    cur_smp_d = cur_smp_q;
    rx_d      = rx_q;
    done      = 1'b0;
    if (start && !busy_q) begin
      sh_d   = ld_sh;
      oes_d  = ld_oe;
      smp_d  = ld_smp;
      cnt_d  = ld_cnt;
      busy_d = 1'b1;
      rd_d   = is_rd;
    end else if (busy_q && fall_stb) begin
      if (cnt_q != '0) begin
        o_d       = sh_q[SH_W-1];
        oe_d      = oes_q[SH_W-1];
        cur_smp_d = smp_q[SH_W-1];
        sh_d      = {sh_q[SH_W-2:0], 1'b0};
        oes_d     = {oes_q[SH_W-2:0], 1'b0};
        smp_d     = {smp_q[SH_W-2:0], 1'b0};
        cnt_d     = cnt_q - CNT_W'(1);
      end else begin
        busy_d    = 1'b0;
        o_d       = 1'b1;
        oe_d      = 1'b0;
        cur_smp_d = 1'b0;
        done      = 1'b1;
      end
    end
    if (busy_q && rise_stb && cur_smp_q) begin
      rx_d = {rx_q[DATA_BITS-2:0], mdio_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      oes_q     <= '0;
      smp_q     <= '0;
      cnt_q     <= '0;
      busy_q    <= 1'b0;
      rd_q      <= 1'b0;
      o_q       <= 1'b1;
      oe_q      <= 1'b0;
      cur_smp_q <= 1'b0;
      rx_q      <= '0;
    end else begin
      sh_q      <= sh_d;
      oes_q     <= oes_d;
      smp_q     <= smp_d;
      cnt_q     <= cnt_d;
      busy_q    <= busy_d;
      rd_q      <= rd_d;
      o_q       <= o_d;
      oe_q      <= oe_d;
      cur_smp_q <= cur_smp_d;
      rx_q      <= rx_d;
    end
  end

  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;
  assign busy    = busy_q;
  assign busy_rd = busy_q && rd_q;
  assign rxd     = rx_q;

  // R11
  mdio_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_stb |=> ($stable(o_q) && $stable(oe_q)));

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fall_stb) |=> busy_q);

  // R9
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rd_q) |-> !oe_q);
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              busy,
  input  logic              busy_rd,
  input  logic              done,
  input  logic [DATA_BITS-1:0] rxd,
  output logic              start,
  output mgmt_cmd_t         new_cmd,
  output logic              cl45,
  output logic              pre_en,
  output logic              en,
  output logic [DATA_BITS-1:0] txd
);
  mgmt_cmd_t            cmd_q, cmd_d;
  logic [DATA_BITS-1:0] txd_q, txd_d, rxd_q, rxd_d;
  logic                 cl45_q, cl45_d, pre_q, pre_d, en_q, en_d;
  logic                 tval_q, tval_d, rval_q, rval_d;
  logic                 cmd_hit, start_rd;

  always_comb begin
    new_cmd  = {reg_wdata[OP_LSB +: 2], reg_wdata[PA_LSB +: FIELD_W],
                reg_wdata[RA_LSB +: FIELD_W]};
    cmd_hit  = reg_wr && (reg_addr == OFS_CMD);
    start    = cmd_hit && en_q && !busy;
    start_rd = op_reads(new_cmd.op, cl45_q);

    cmd_d  = start ? new_cmd : cmd_q;
    txd_d  = (reg_wr && reg_addr == OFS_TXD) ? reg_wdata[DATA_BITS-1:0] : txd_q;
    cl45_d = (reg_wr && reg_addr == OFS_MODE) ? reg_wdata[CL45_BIT] : cl45_q;
    pre_d  = (reg_wr && reg_addr == OFS_MODE) ? reg_wdata[PRE_BIT] : pre_q;
    en_d   = (reg_wr && reg_addr == OFS_EN) ? reg_wdata[EN_BIT] : en_q;

    rval_d = rval_q;
    rxd_d  = rxd_q;
    tval_d = tval_q;
    if (start && start_rd) rval_d = 1'b0;
    else if (done && busy_rd) begin
      rval_d = 1'b1;
      rxd_d  = rxd;
    end
    if (start && !start_rd) tval_d = 1'b0;
    else if (done && !busy_rd) tval_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      txd_q  <= '0;
      rxd_q  <= '0;
      cl45_q <= 1'b0;
      pre_q  <= 1'b0;
      en_q   <= 1'b0;
      tval_q <= 1'b0;
      rval_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      txd_q  <= txd_d;
      rxd_q  <= rxd_d;
      cl45_q <= cl45_d;
      pre_q  <= pre_d;
      en_q   <= en_d;
      tval_q <= tval_d;
      rval_q <= rval_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CMD: begin
        reg_rdata[OP_LSB +: 2]       = cmd_q.op;
        reg_rdata[PA_LSB +: FIELD_W] = cmd_q.port;
        reg_rdata[RA_LSB +: FIELD_W] = cmd_q.addr;
      end
      OFS_TXD: begin
        reg_rdata[DATA_BITS-1:0] = txd_q;
        reg_rdata[VAL_BIT]       = tval_q;
        reg_rdata[BUSY_BIT]      = busy && !busy_rd;
      end
      OFS_RXD: begin
        reg_rdata[DATA_BITS-1:0] = rxd_q;
        reg_rdata[VAL_BIT]       = rval_q;
        reg_rdata[BUSY_BIT]      = busy_rd;
      end
      OFS_MODE: begin
        reg_rdata[CL45_BIT] = cl45_q;
        reg_rdata[PRE_BIT]  = pre_q;
      end
      OFS_EN:  reg_rdata[EN_BIT] = en_q;
      default: reg_rdata = '0;
    endcase
  end

  assign cl45   = cl45_q;
  assign pre_en = pre_q;
  assign en     = en_q;
  assign txd    = txd_q;

  // R4
  busy_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && busy) |=> $stable(cmd_q));

  // R3
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !busy) |=> !busy);

  // R10
  rval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_rd) |=> !rval_q);

  // R9
  rval_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && busy_rd) |=> rval_q);

  // R12
  tval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !start_rd) |=> !tval_q);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic                 start, cl45, pre_en, en;
  logic                 busy, busy_rd, done;
  logic                 rise_stb, fall_stb;
  logic [DATA_BITS-1:0] txd, rxd;
  mgmt_cmd_t            new_cmd;

  mdio_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .busy_rd   (busy_rd),
    .done      (done),
    .rxd       (rxd),
    .start     (start),
    .new_cmd   (new_cmd),
    .cl45      (cl45),
    .pre_en    (pre_en),
    .en        (en),
    .txd       (txd)
  );

  mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (en || busy),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cmd      (new_cmd),
    .cl45     (cl45),
    .pre_en   (pre_en),
    .txd      (txd),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .busy     (busy),
    .busy_rd  (busy_rd),
    .done     (done),
    .rxd      (rxd)
  );
endmodule

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #2 clk = ~clk;

  mdio_master #(.HALF_DIV(HALF)) i_mdio_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe));

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // PHY model and bit recorder
  logic        mon_on = 1'b0, seen_fall = 1'b0;
  int          rec_n = 0, pre_n = 0;
  logic [63:0] rec_o = '0, rec_oe = '0;
  logic [15:0] phy_resp = '0;

  always @(negedge mdc) begin
    int j;
    if (mon_on) begin
      seen_fall = 1'b1;
      j = rec_n - pre_n - 16;
      if (j >= 0 && j < 16) mdio_i = phy_resp[15-j];
      else mdio_i = 1'b1;
    end
  end

  always @(posedge mdc) begin
    if (mon_on && seen_fall) begin
      rec_o  = {rec_o[62:0], mdio_o};
      rec_oe = {rec_oe[62:0], mdio_oe};
      rec_n++;
    end
  end

  // MDIO may only move when MDC falls
  bit   edge_on = 1'b0;
  logic p_mdc, p_o, p_oe;
  int   edge_bad = 0;
  always @(negedge clk) begin
    if (edge_on) begin
      if ((mdio_o !== p_o || mdio_oe !== p_oe) && !(p_mdc === 1'b1 && mdc === 1'b0))
        edge_bad++;
    end
    p_mdc = mdc; p_o = mdio_o; p_oe = mdio_oe;
  end

  task automatic reg_write(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [63:0] cmd_word(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra);
    return (64'(op) << 16) | (64'(pa) << 8) | 64'(ra);
  endfunction

  function automatic logic exp_read(input logic c45, input logic [1:0] op);
    if (c45) return op == 2'd3 || op == 2'd2;
    return op == 2'd1;
  endfunction

  function automatic logic [63:0] exp_bits(input logic c45, input logic pre, input logic [1:0] op,
                                           input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
    logic [31:0] f;
    logic [1:0]  wop;
    logic        rd;
    rd  = exp_read(c45, op);
    wop = c45 ? op : (rd ? 2'b10 : 2'b01);
    f   = {(c45 ? 2'b00 : 2'b01), wop, pa, ra, (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : d)};
    return pre ? {32'hFFFF_FFFF, f} : {32'h0, f};
  endfunction

  function automatic logic [63:0] exp_oe(input logic c45, input logic pre, input logic [1:0] op);
    logic [31:0] f;
    logic        rd;
    rd = exp_read(c45, op);
    f  = {14'h3FFF, (rd ? 2'b00 : 2'b11), (rd ? 16'h0 : 16'hFFFF)};
    return pre ? {32'hFFFF_FFFF, f} : {32'h0, f};
  endfunction

  task automatic wait_idle(input logic [7:0] a);
    logic [63:0] v;
    for (int k = 0; k < 3000; k++) begin
      reg_read(a, v);
      if (!v[17]) break;
    end
  endtask

  task automatic run_txn(input logic c45, input logic pre, input logic [1:0] op,
                         input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] d, input logic [15:0] resp);
    logic [63:0] v, eo, eoe;
    logic        rd;
    logic [7:0]  sa;
    rd = exp_read(c45, op);
    sa = rd ? 8'h10 : 8'h08;
    reg_write(8'h18, (64'(c45) << 24) | (64'(pre) << 12));
    reg_write(8'h08, 64'(d));
    phy_resp = resp; pre_n = pre ? 32 : 0;
    rec_n = 0; rec_o = '0; rec_oe = '0; seen_fall = 1'b0;
    reg_write(8'h00, cmd_word(op, pa, ra));
    mon_on = 1'b1;
    reg_read(sa, v);
    chk(v[17] == 1'b1, "R2 pending set", 64'(v[17]), 64'd1);
    if (rd) chk(v[16] == 1'b0, "R10 read valid cleared on issue", 64'(v[16]), 64'd0);
    else    chk(v[16] == 1'b0, "R12 write valid cleared on issue", 64'(v[16]), 64'd0);
    wait_idle(sa);
    mon_on = 1'b0;
    reg_read(sa, v);
    chk(v[17] == 1'b0, "R2 pending cleared", 64'(v[17]), 64'd0);
    eo  = exp_bits(c45, pre, op, pa, ra, d);
    eoe = exp_oe(c45, pre, op);
    chk(rec_n == (pre ? 64 : 32), "R7 bit count", 64'(rec_n), pre ? 64'd64 : 64'd32);
    chk(rec_oe == eoe, "R8 R9 drive pattern", rec_oe, eoe);
    chk((rec_o & eoe) == (eo & eoe), c45 ? "R6 frame bits" : "R5 frame bits", rec_o & eoe, eo & eoe);
    if (rd) begin
      chk(v[16] == 1'b1, "R9 read valid", 64'(v[16]), 64'd1);
      chk(v[15:0] == resp, "R9 read data", 64'(v[15:0]), 64'(resp));
    end else begin
      chk(v[16] == 1'b1, "R12 write valid", 64'(v[16]), 64'd1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [1:0]  op;
    logic        c45;
    int          seed_dummy;
    int          t0, per, highs;
    seed_dummy = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins idle", {62'd0, mdc, mdio_oe}, 64'd0);
    for (int a = 0; a <= 32; a += 8) begin
      reg_read(8'(a), v);
      chk(v == 64'd0, "R1 register zero", v, 64'd0);
    end
    edge_on = 1'b1;

    reg_write(8'h20, 64'd1);

    // R11 MDC period
    @(posedge mdc); t0 = int'($time);
    @(posedge mdc); per = (int'($time) - t0) / 4;
    chk(per == 2 * HALF, "R11 mdc period", 64'(per), 64'(2 * HALF));

    // directed: C22 write/read, C45 two-step read
    run_txn(1'b0, 1'b1, 2'd0, 5'h01, 5'h00, 16'hA5C3, 16'h0);
    run_txn(1'b0, 1'b0, 2'd1, 5'h1F, 5'h1F, 16'h0, 16'h8001);
    run_txn(1'b1, 1'b1, 2'd0, 5'h03, 5'h07, 16'h1234, 16'h0);
    run_txn(1'b1, 1'b1, 2'd3, 5'h03, 5'h07, 16'h0, 16'hBEEF);
    run_txn(1'b1, 1'b0, 2'd1, 5'h10, 5'h01, 16'hFFFF, 16'h0);
    run_txn(1'b0, 1'b1, 2'd1, 5'h00, 5'h00, 16'h0, 16'h0000);

    // R4 command and data rewrite during a running frame
    reg_write(8'h18, 64'd1 << 12);
    reg_write(8'h08, 64'h0000_C0DE);
    rec_n = 0; rec_o = '0; rec_oe = '0; seen_fall = 1'b0; pre_n = 32;
    reg_write(8'h00, cmd_word(2'd0, 5'h05, 5'h09));
    mon_on = 1'b1;
    reg_write(8'h00, cmd_word(2'd1, 5'h1A, 5'h02));
    reg_write(8'h08, 64'h0000_7777);
    reg_read(8'h00, v);
    chk(v == cmd_word(2'd0, 5'h05, 5'h09), "R4 busy command ignored", v, cmd_word(2'd0, 5'h05, 5'h09));
    wait_idle(8'h08);
    mon_on = 1'b0;
    chk((rec_o & exp_oe(1'b0, 1'b1, 2'd0)) == exp_bits(1'b0, 1'b1, 2'd0, 5'h05, 5'h09, 16'hC0DE),
        "R4 frame kept loaded data", rec_o, exp_bits(1'b0, 1'b1, 2'd0, 5'h05, 5'h09, 16'hC0DE));
    reg_read(8'h08, v);
    chk(v[15:0] == 16'h7777, "R4 data register updated", 64'(v[15:0]), 64'h7777);
    reg_read(8'h10, v);
    chk(v[17] == 1'b0, "R4 no read started", 64'(v[17]), 64'd0);

    // R3 disabled interface
    reg_write(8'h20, 64'd0);
    repeat (4) @(negedge clk);
    reg_write(8'h00, cmd_word(2'd1, 5'h11, 5'h11));
    highs = 0;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (mdc || mdio_oe) highs++;
    end
    chk(highs == 0, "R3 pins quiet while disabled", 64'(highs), 64'd0);
    reg_read(8'h00, v);
    chk(v == cmd_word(2'd0, 5'h05, 5'h09), "R3 command ignored", v, cmd_word(2'd0, 5'h05, 5'h09));
    reg_read(8'h10, v);
    chk(v[17] == 1'b0, "R3 read not pending", 64'(v[17]), 64'd0);
    reg_read(8'h08, v);
    chk(v[17] == 1'b0, "R3 write not pending", 64'(v[17]), 64'd0);
    reg_write(8'h20, 64'd1);

    // constrained random
    for (int i = 0; i < 30; i++) begin
      c45 = 1'($urandom % 2);
      if (c45) begin
        case ($urandom % 3)
          0: op = 2'd0;
          1: op = 2'd1;
          default: op = 2'd3;
        endcase
      end else op = 2'($urandom % 2);
      run_txn(c45, 1'($urandom % 2), op, 5'($urandom), 5'($urandom),
              16'($urandom), 16'($urandom));
    end

    chk(edge_bad == 0, "R11 mdio moves only on mdc fall", 64'(edge_bad), 64'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule